// File: doc/BRIEF.md
# Bimodal Branch Predictor Table

This block keeps a small table of per-branch predictors. The table is indexed by the low bits of a branch address, with the byte-offset bits dropped. In every cycle it answers a lookup with a taken or not-taken guess for the address on the lookup port. It also accepts one update per cycle, which carries the branch address and the resolved outcome. The update trains the entry that the address selects.

A build-time parameter picks the entry type:

- Two-bit saturating counters, which give hysteresis.
- A one-bit scheme that simply remembers the last outcome.

Both entry types sit behind the same ports, so miss totals for the same trace can be compared directly, for example on loop exits or phase changes.

The block has two statistics counters. One counts lookups and the other counts mispredicted updates, so a trace's miss total can be read at the ports. There are no tags. Two branches whose addresses share the index bits share one entry, and nothing detects the collision.

Top module: `bimodal_pred`

## Requirements
- R1: In two-bit mode the lookup output `lkp_taken_o` is combinational and equals bit 1 (the upper bit) of the selected counter: 1 means taken, 0 means not-taken.
- R2: In two-bit mode a valid update with outcome taken (`upd_taken_i`=1) raises the selected counter by one and holds it at 3, never wrapping to 0. From 2, alternating taken/not-taken keeps the counter between 2 and 3 with a taken prediction throughout.
- R3: In two-bit mode a valid update with outcome not-taken lowers the selected counter by one and holds it at 0, never wrapping to 3. From 3, two not-taken updates are needed before the prediction turns to not-taken.
- R4: The entry index is address bits [IDX_W+1:2]. With IDX_W=2, addresses 0x1004 and 0x1014 select the same entry 1.
- R5: After reset every counter holds 2 (weakly taken), every one-bit entry holds taken, and both statistics counters read 0.
- R6: In one-bit mode each entry stores the last update outcome and predicts it. A taken-biased loop of seven taken and one not-taken outcome costs 2 misses per iteration after the first, against 1 in two-bit mode.
- R7: A lookup and an update of the same entry in one cycle return the pre-update prediction. The entry changes only on the rising clock edge of a cycle with `upd_valid_i`=1.
- R8: `lkp_count_o` increases by one after every cycle with `lkp_valid_i`=1.
- R9: `miss_count_o` increases by one after every valid update whose outcome differs from the prediction held by the selected entry in that cycle.
- R10: Both statistics counters hold at all-ones instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lkp_valid_i | input | 1 | Lookup present this cycle (counted) |
| lkp_pc_i | input | ADDR_W | Branch address to predict |
| lkp_taken_o | output | 1 | Prediction for `lkp_pc_i`, 1 = taken |
| upd_valid_i | input | 1 | Resolved branch present this cycle |
| upd_pc_i | input | ADDR_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved outcome, 1 = taken |
| lkp_count_o | output | CNT_W | Saturating count of lookups |
| miss_count_o | output | CNT_W | Saturating count of mispredicted updates |

## Verification
A lookup and an update can land in the same cycle, and when both select one entry the lookup must see the state from before the update. The bench provokes this with a directed cycle in which both ports name the same address. It then lets random traffic, with both valids often high and a narrow index space, hit the case repeatedly. Each case is judged by comparing the combinational guess, sampled just before the clock edge, with a model that applies updates only after that sample. A following lookup then confirms that the update did land. The miss counter falls in the same cycle too: it must be judged on the entry state from before the update.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_MIN   = 2'd0;
  localparam ctr2_t CTR_MAX   = 2'd3;
  localparam ctr2_t CTR_RESET = 2'd2;  // weakly taken

  function automatic ctr2_t ctr_step(ctr2_t c, logic taken);
    if (taken) return (c == CTR_MAX) ? c : c + 2'd1;
    else       return (c == CTR_MIN) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_index.sv
`timescale 1ns/1ps
module bp_index #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 2
) (
  input  logic [ADDR_W-1:0] pc_i,
  output logic [IDX_W-1:0]  idx_o
);
  assign idx_o = pc_i[IDX_W+1:2];

  logic unused_pc;
  assign unused_pc = ^{pc_i[ADDR_W-1:IDX_W+2], pc_i[1:0]};
endmodule

// File: rtl/bp_entry.sv
`timescale 1ns/1ps
module bp_entry
  import bp_pkg::*;
#(
  parameter bit ONE_BIT = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  we_i,
  input  logic  taken_i,
  output logic  pred_o,
  output ctr2_t state_o
);
  if (ONE_BIT) begin : g_last
    logic last_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   last_q <= 1'b1;
      else if (we_i) last_q <= taken_i;
    end
    assign pred_o  = last_q;
    assign state_o = {last_q, last_q};
  end else begin : g_ctr
    ctr2_t ctr_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   ctr_q <= CTR_RESET;
      else if (we_i) ctr_q <= ctr_step(ctr_q, taken_i);
    end
    assign pred_o  = ctr_q[1];
    assign state_o = ctr_q;
  end
endmodule

// File: rtl/bp_sat_cnt.sv
`timescale 1ns/1ps
module bp_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o = cnt_q;
endmodule

// File: rtl/bimodal_pred.sv
`timescale 1ns/1ps
module bimodal_pred
  import bp_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 2,
  parameter bit ONE_BIT = 1'b0,
  parameter int CNT_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lkp_valid_i,
  input  logic [ADDR_W-1:0] lkp_pc_i,
  output logic              lkp_taken_o,
  input  logic              upd_valid_i,
  input  logic [ADDR_W-1:0] upd_pc_i,
  input  logic              upd_taken_i,
  output logic [CNT_W-1:0]  lkp_count_o,
  output logic [CNT_W-1:0]  miss_count_o
);
  localparam int ENTRIES = 1 << IDX_W;

  logic [IDX_W-1:0]          lkp_idx;
  logic [IDX_W-1:0]          upd_idx;
  logic [ENTRIES-1:0]        pred_vec;
  ctr2_t [ENTRIES-1:0]       state_vec;
  logic                      upd_pred;
  logic                      miss_inc;

  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_lkp_idx (
    .pc_i (lkp_pc_i),
    .idx_o(lkp_idx)
  );

  bp_index #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_upd_idx (
    .pc_i (upd_pc_i),
    .idx_o(upd_idx)
  );

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    bp_entry #(.ONE_BIT(ONE_BIT)) u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .we_i   (upd_valid_i && (upd_idx == IDX_W'(i))),
      .taken_i(upd_taken_i),
      .pred_o (pred_vec[i]),
      .state_o(state_vec[i])
    );
  end

  // reads see registered state, so same-cycle updates are not visible yet
  assign lkp_taken_o = pred_vec[lkp_idx];
  assign upd_pred    = pred_vec[upd_idx];
  assign miss_inc    = upd_valid_i && (upd_taken_i != upd_pred);

  bp_sat_cnt #(.W(CNT_W)) u_lkp_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (lkp_valid_i),
    .count_o(lkp_count_o)
  );

  bp_sat_cnt #(.W(CNT_W)) u_miss_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (miss_inc),
    .count_o(miss_count_o)
  );
endmodule

// File: rtl/bimodal_pred_chk.sv
`timescale 1ns/1ps
module bimodal_pred_chk
  import bp_pkg::*;
#(
  parameter int IDX_W   = 2,
  parameter bit ONE_BIT = 1'b0,
  parameter int CNT_W   = 16
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic                        lkp_valid_i,
  input logic                        lkp_taken_o,
  input logic                        upd_valid_i,
  input logic                        upd_taken_i,
  input logic [IDX_W-1:0]            lkp_idx,
  input logic [IDX_W-1:0]            upd_idx,
  input ctr2_t [(1<<IDX_W)-1:0]      state_vec,
  input logic [CNT_W-1:0]            lkp_count_o,
  input logic [CNT_W-1:0]            miss_count_o
);
  logic [IDX_W-1:0] upd_idx_q;
  ctr2_t            upd_state;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) upd_idx_q <= '0;
    else         upd_idx_q <= upd_idx;
  end

  assign upd_state = state_vec[upd_idx];

  a_r1_pred_msb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_taken_o == state_vec[lkp_idx][1]);

  a_r2_sat_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ONE_BIT && upd_valid_i && upd_taken_i && upd_state == CTR_MAX)
      |=> state_vec[upd_idx_q] == CTR_MAX);

  a_r3_sat_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ONE_BIT && upd_valid_i && !upd_taken_i && upd_state == CTR_MIN)
      |=> state_vec[upd_idx_q] == CTR_MIN);

  a_r7_no_upd_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(state_vec));

  a_r8_lkp_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lkp_valid_i && lkp_count_o != '1)
      |=> lkp_count_o == CNT_W'($past(lkp_count_o) + 1'b1));

  a_r9_miss_inc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_valid_i && upd_taken_i != upd_state[1] && miss_count_o != '1)
      |=> miss_count_o == CNT_W'($past(miss_count_o) + 1'b1));

  a_r10_miss_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_count_o == '1 |=> miss_count_o == '1);
endmodule

bind bimodal_pred bimodal_pred_chk #(
  .IDX_W  (IDX_W),
  .ONE_BIT(ONE_BIT),
  .CNT_W  (CNT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .lkp_valid_i (lkp_valid_i),
  .lkp_taken_o (lkp_taken_o),
  .upd_valid_i (upd_valid_i),
  .upd_taken_i (upd_taken_i),
  .lkp_idx     (lkp_idx),
  .upd_idx     (upd_idx),
  .state_vec   (state_vec),
  .lkp_count_o (lkp_count_o),
  .miss_count_o(miss_count_o)
);

// File: tb/sim_bimodal_pred.sv
`timescale 1ns/1ps
module sim_bimodal_pred;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lkp_valid = 1'b0;
  logic [31:0] lkp_pc = '0;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;

  logic        p0, p1, p2;
  logic [15:0] lc0, mc0, lc1, mc1;
  logic [3:0]  lc2, mc2;

  int tests = 0;
  int fails = 0;

  int m2[4];
  bit m1[4];
  int lk, ms2, ms1, lk_s, ms2_s;

  always #4 clk = ~clk;

  bimodal_pred #(.ONE_BIT(1'b0), .CNT_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_valid_i(lkp_valid), .lkp_pc_i(lkp_pc),
    .lkp_taken_o(p0), .upd_valid_i(upd_valid), .upd_pc_i(upd_pc),
    .upd_taken_i(upd_taken), .lkp_count_o(lc0), .miss_count_o(mc0));

  bimodal_pred #(.ONE_BIT(1'b1), .CNT_W(16)) u1 (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_valid_i(lkp_valid), .lkp_pc_i(lkp_pc),
    .lkp_taken_o(p1), .upd_valid_i(upd_valid), .upd_pc_i(upd_pc),
    .upd_taken_i(upd_taken), .lkp_count_o(lc1), .miss_count_o(mc1));

  bimodal_pred #(.ONE_BIT(1'b0), .CNT_W(4)) u2 (
    .clk_i(clk), .rst_ni(rst_ni), .lkp_valid_i(lkp_valid), .lkp_pc_i(lkp_pc),
    .lkp_taken_o(p2), .upd_valid_i(upd_valid), .upd_pc_i(upd_pc),
    .upd_taken_i(upd_taken), .lkp_count_o(lc2), .miss_count_o(mc2));

  function automatic int idx_of(logic [31:0] pc);
    return int'(pc[3:2]);
  endfunction

  function automatic int sat(int v, int mx);
    return (v >= mx) ? mx : v + 1;
  endfunction

  function automatic int ctr_next(int c, bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 4; i++) begin m2[i] = 2; m1[i] = 1'b1; end
    lk = 0; ms2 = 0; ms1 = 0; lk_s = 0; ms2_s = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    lkp_valid = 1'b0; upd_valid = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    model_reset();
  endtask

  // drive at negedge, sample before next posedge, then advance the model
  task automatic step(bit lv, logic [31:0] lpc, bit uv, logic [31:0] upc, bit ut);
    int li, ui;
    bit pr2, pr1;
    @(negedge clk);
    lkp_valid = lv; lkp_pc = lpc; upd_valid = uv; upd_pc = upc; upd_taken = ut;
    #1;
    li = idx_of(lpc);
    check("R1 two-bit guess", int'(p0), int'(m2[li] >= 2));
    check("R6 one-bit guess", int'(p1), int'(m1[li]));
    check("R1 small-count guess", int'(p2), int'(m2[li] >= 2));
    check("R8 lookups", int'(lc0), lk);
    check("R10 lookups sat", int'(lc2), lk_s);
    check("R9 misses two-bit", int'(mc0), ms2);
    check("R9 misses one-bit", int'(mc1), ms1);
    check("R10 misses sat", int'(mc2), ms2_s);
    if (lv) begin lk = sat(lk, 65535); lk_s = sat(lk_s, 15); end
    if (uv) begin
      ui  = idx_of(upc);
      pr2 = (m2[ui] >= 2);
      pr1 = m1[ui];
      if (pr2 != ut) begin ms2 = sat(ms2, 65535); ms2_s = sat(ms2_s, 15); end
      if (pr1 != ut) ms1 = sat(ms1, 65535);
      m2[ui] = ctr_next(m2[ui], ut);
      m1[ui] = ut;
    end
  endtask

  task automatic look(logic [31:0] pc);
    step(1'b1, pc, 1'b0, 32'h0, 1'b0);
  endtask

  task automatic upd(logic [31:0] pc, bit t);
    step(1'b0, 32'h0, 1'b1, pc, t);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL R1 watchdog act=0 exp=1");
    finish_run();
  end

  initial begin
    model_reset();
    do_reset();

    // R5: reset state
    check("R5 misses zero", int'(mc0), 0);
    check("R5 lookups zero", int'(lc0), 0);
    for (int a = 0; a < 4; a++) begin
      look(32'h1000 + 32'(a * 4));
      check("R5 weak taken", int'(p0), 1);
      check("R5 one-bit taken", int'(p1), 1);
    end

    // R2/R3 saturation both ends, two not-taken to flip
    do_reset();
    for (int k = 0; k < 6; k++) upd(32'h1000, 1'b1);
    look(32'h1000);
    check("R2 saturated taken", int'(p0), 1);
    check("R2 no cold miss", int'(mc0), 0);
    upd(32'h1000, 1'b0);
    look(32'h1000);
    check("R3 one N keeps taken", int'(p0), 1);
    upd(32'h1000, 1'b0);
    look(32'h1000);
    check("R3 two N flip", int'(p0), 0);
    check("R3 misses after flip", int'(mc0), 2);
    for (int k = 0; k < 3; k++) upd(32'h1000, 1'b0);
    upd(32'h1000, 1'b1);
    look(32'h1000);
    check("R3 floor no wrap", int'(p0), 0);
    check("R9 two-bit misses", int'(mc0), 3);
    check("R6 one-bit misses", int'(mc1), 2);

    // R6: taken-biased loop, 3 iterations of 7T+1N
    do_reset();
    for (int it = 0; it < 3; it++) begin
      for (int k = 0; k < 7; k++) upd(32'h1004, 1'b1);
      upd(32'h1004, 1'b0);
    end
    look(32'h1004);
    check("R6 loop misses two-bit", int'(mc0), 3);
    check("R6 loop misses one-bit", int'(mc1), 5);

    // R4: aliasing of 0x1004 and 0x1014
    do_reset();
    upd(32'h1004, 1'b0);
    upd(32'h1004, 1'b0);
    look(32'h1014);
    check("R4 alias shares entry", int'(p0), 0);
    look(32'h1008);
    check("R4 neighbour untouched", int'(p0), 1);

    // R2: alternation from 2 stays taken
    do_reset();
    for (int k = 0; k < 4; k++) begin
      upd(32'h100C, 1'b1);
      look(32'h100C);
      check("R2 alternation taken", int'(p0), 1);
      upd(32'h100C, 1'b0);
    end
    look(32'h100C);
    check("R2 alternation misses", int'(mc0), 4);

    // R7: same-cycle lookup and update, and ignored update
    do_reset();
    step(1'b1, 32'h1000, 1'b1, 32'h1000, 1'b0);
    check("R7 pre-update guess", int'(p0), 1);
    look(32'h1000);
    check("R7 update landed", int'(p0), 0);
    step(1'b0, 32'h0, 1'b0, 32'h1000, 1'b1);
    step(1'b0, 32'h0, 1'b0, 32'h1000, 1'b1);
    look(32'h1000);
    check("R7 invalid update ignored", int'(p0), 0);

    // R8/R10: lookup count and saturation of the 4-bit copy
    do_reset();
    for (int k = 0; k < 20; k++) look(32'(k * 4));
    look(32'h0);
    check("R8 lookup count", int'(lc0), 20);
    check("R10 lookup count held", int'(lc2), 15);
    for (int k = 0; k < 20; k++) begin
      upd(32'h1008, 1'b1);
      upd(32'h1008, 1'b0);
      upd(32'h1008, 1'b0);
    end
    look(32'h0);
    check("R10 miss count held", int'(mc2), 15);

    // random mix, narrow index space for frequent collisions
    do_reset();
    void'($urandom(32'd1234));
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] a, b;
      bit          lv, uv, ut;
      a  = $urandom();
      b  = $urandom();
      if ($urandom_range(3) == 0) b[3:2] = a[3:2];
      lv = ($urandom_range(3) != 0);
      uv = ($urandom_range(3) != 0);
      ut = ($urandom_range(9) < 7);
      step(lv, a, uv, b, ut);
    end

    finish_run();
  end
endmodule